// File: doc/BRIEF.md
# Integrator-Feedback PWM DAC Controller

This block turns a stream of target samples into a PWM waveform that drives an external inverting integrator. The PWM setting does not set the output level. It sets how fast the integrator output moves. A setting equal to the calibrated centre code holds the output steady. A setting above the centre makes the output fall, and a setting below it makes the output rise. An ADC reads the integrator output back. That reading is always one sample late, because the conversion cannot finish inside the current sample.

For each sample, the host pulses a strobe and presents two values: the last ADC reading and the new target. The block first predicts the present integrator voltage. It takes the lagged reading and adds the movement that the previous setting should have caused. The prediction is clamped to the ADC range. The block then picks the setting that would close the remaining error in one sample period. Gain is alpha ADC counts per unit of offset from the centre, with alpha a power of two. The new setting is held in a register, so the next prediction can use it. The PWM counter loads this setting only when a new period starts.

Top module: `ifb_dac_ctrl`

## Requirements
- R1: After synchronous reset, `setting_o` equals the centre code (76), and the PWM output is high for 77 of every 160 clocks.
- R2: One PWM period lasts 160 clocks. Within a period, `pwm_o` is high for exactly setting+1 clocks. A setting of 159 keeps the output high all the time, and a setting of 0 gives a single high clock per period.
- R3: The predicted voltage is the ADC value plus 4 × (76 − previous setting), where alpha = 4 and the shift is 2. The prediction is limited to the range 0..1023 before any further use.
- R4: The new setting is 76 + floor((prediction − target) / 4). Rounding is toward negative infinity, so an error of −1 gives 75.
- R5: The computed setting is saturated to the range 0..159.
- R6: A new setting leaves the PWM period that is already running unchanged. It takes effect from the next period boundary.
- R7: `setting_o` is updated one clock after a cycle in which `smp_valid` is high. It holds its value in every other cycle, whatever the ADC and target inputs do. The held value is the "previous setting" used by the next prediction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, one PWM count per cycle |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe: compute a new setting from the inputs below |
| adc_code | input | 10 | Previous ADC reading of the integrator output |
| target | input | 10 | Target voltage code for this sample |
| pwm_o | output | 1 | PWM drive to the integrator |
| setting_o | output | 8 | Most recently computed PWM setting |

## Verification
The hardest case to reach from the ports is a setting that changes in the middle of a running PWM period. The bench first drives the setting to a low value. It then waits for the falling edge of `pwm_o`, which shows exactly where the hidden counter stands. It issues the next sample right at that point. It then checks that the rest of the old period stays low, and that the following period carries the new high time. The clamping corners need a particular history before them. Before the final sample, the previous setting is steered to 0 or to 159, so that the prediction runs past the ADC range.

// File: rtl/ifb_dac_pkg.sv
package ifb_dac_pkg;

    // Limit an integer to the closed range [lo, hi].
    function automatic int clamp_i(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // Divide by 2**sh, rounding toward negative infinity.
    function automatic int floor_shr(input int v, input int sh);
        return v >>> sh;
    endfunction

endpackage

// File: rtl/ifb_estimator.sv
module ifb_estimator
    import ifb_dac_pkg::*;
#(
    parameter int ADC_W    = 10,
    parameter int PERIOD   = 160,
    parameter int CENTRE   = 76,
    parameter int ALPHA_SH = 2,
    localparam int SET_W   = $clog2(PERIOD),
    localparam int ADC_MAX = (1 << ADC_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [ADC_W-1:0] adc_code,
    input  logic [ADC_W-1:0] target,
    output logic [SET_W-1:0] setting_q
);

    int               est_i;
    int               err_i;
    int               nxt_i;
    logic [SET_W-1:0] nxt_set;

    // One-step prediction from the lagged reading, then the steering step.
    always_comb begin
        est_i   = int'(adc_code) + ((CENTRE - int'(setting_q)) <<< ALPHA_SH);
        est_i   = clamp_i(est_i, 0, ADC_MAX);
        err_i   = floor_shr(est_i - int'(target), ALPHA_SH);
        nxt_i   = clamp_i(CENTRE + err_i, 0, PERIOD - 1);
        nxt_set = SET_W'(nxt_i);
    end

    always_ff @(posedge clk) begin
        if (rst)            setting_q <= SET_W'(CENTRE);
        else if (smp_valid) setting_q <= nxt_set;
    end

    assert_setting_range_R5: assert property (@(posedge clk) disable iff (rst)
        int'(setting_q) < PERIOD);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(setting_q));

    assert_centre_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && adc_code == target && int'(setting_q) == CENTRE)
        |=> int'(setting_q) == CENTRE);

endmodule

// File: rtl/ifb_pwm_core.sv
module ifb_pwm_core #(
    parameter int PERIOD  = 160,
    parameter int CENTRE  = 76,
    localparam int SET_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] next_set,
    output logic             pwm_o
);

    logic [SET_W-1:0] cnt;
    logic [SET_W-1:0] active;
    logic             wrap;

    assign wrap = (cnt == SET_W'(PERIOD - 1));

    // The setting is latched only at the period boundary.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= SET_W'(CENTRE);
        end else if (wrap) begin
            cnt    <= '0;
            active <= next_set;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    assign pwm_o = (cnt <= active);

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) < PERIOD);

    assert_period_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) == PERIOD - 1 |=> cnt == '0);

    assert_active_stable_R6: assert property (@(posedge clk) disable iff (rst)
        cnt != '0 |-> $stable(active));

endmodule

// File: rtl/ifb_dac_ctrl.sv
module ifb_dac_ctrl #(
    parameter int ADC_W    = 10,
    parameter int PERIOD   = 160,
    parameter int CENTRE   = 76,
    parameter int ALPHA_SH = 2,
    localparam int SET_W   = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [ADC_W-1:0] adc_code,
    input  logic [ADC_W-1:0] target,
    output logic             pwm_o,
    output logic [SET_W-1:0] setting_o
);

    logic [SET_W-1:0] setting_q;

    ifb_estimator #(
        .ADC_W(ADC_W), .PERIOD(PERIOD), .CENTRE(CENTRE), .ALPHA_SH(ALPHA_SH)
    ) u_est (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .adc_code(adc_code), .target(target), .setting_q(setting_q)
    );

    ifb_pwm_core #(
        .PERIOD(PERIOD), .CENTRE(CENTRE)
    ) u_pwm (
        .clk(clk), .rst(rst), .next_set(setting_q), .pwm_o(pwm_o)
    );

    assign setting_o = setting_q;

endmodule

// File: tb/sim_ifb_dac_ctrl.sv
module sim_ifb_dac_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_valid = 1'b0;
    logic [9:0] adc_code = '0;
    logic [9:0] target = '0;
    logic       pwm_o;
    logic [7:0] setting_o;

    int n_cmp = 0;
    int n_bad = 0;
    int prev  = 76;

    always #2 clk = ~clk;

    ifb_dac_ctrl u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .adc_code(adc_code), .target(target),
        .pwm_o(pwm_o), .setting_o(setting_o)
    );

    function automatic int model(input int adc, input int tgt, input int p);
        int est, d, q, n;
        est = adc + 4 * (76 - p);
        if (est < 0) est = 0;
        if (est > 1023) est = 1023;
        d = est - tgt;
        q = (d >= 0) ? d / 4 : -((-d + 3) / 4);
        n = 76 + q;
        if (n < 0) n = 0;
        if (n > 159) n = 159;
        return n;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sample(input int adc, input int tgt, input string req);
        int exp;
        exp = model(adc, tgt, prev);
        @(negedge clk);
        adc_code  = 10'(adc);
        target    = 10'(tgt);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        check(req, int'(setting_o), exp);
        prev = exp;
    endtask

    task automatic set_to(input int a);
        int adc;
        adc = 512 + 4 * (a - 76) - 4 * (76 - prev);
        if (adc < 0) adc = 0;
        if (adc > 1023) adc = 1023;
        sample(adc, 512, "R4");
    endtask

    // Any 160-cycle window with a constant setting holds setting+1 high cycles.
    task automatic duty(input string req);
        int hi;
        repeat (170) @(negedge clk);
        hi = 0;
        for (int i = 0; i < 160; i++) begin
            @(negedge clk);
            if (pwm_o) hi++;
        end
        check(req, hi, prev + 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int hi, last, b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset setting", int'(setting_o), 76);
        duty("R1 reset duty");

        // Fixed point at the centre, and floor rounding.
        sample(500, 500, "R4 centre");
        sample(100, 101, "R4 floor of -1");
        check("R4 floor value", prev, 75);

        // Estimate clamping at the top and the bottom of the ADC range.
        set_to(0);
        check("R5 reach 0", prev, 0);
        sample(1000, 1023, "R3 clamp high");
        check("R3 clamp high value", prev, 76);
        set_to(159);
        check("R5 reach 159", prev, 159);
        sample(10, 0, "R3 clamp low");
        check("R3 clamp low value", prev, 76);

        // Saturation of the result.
        sample(1023, 0, "R5 saturate high");
        sample(0, 1023, "R5 saturate low");

        // Duty at the extremes and in the middle.
        set_to(159); duty("R2 full duty");
        set_to(0);   duty("R2 minimum duty");
        set_to(100); duty("R2 mid duty");

        // Sweep of reading/target pairs with a running previous setting.
        for (int a = 0; a < 1024; a += 31)
            for (int t = 0; t < 1024; t += 37)
                sample(a, t, "R3/R4 sweep");

        // Holding without a strobe.
        set_to(30);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            adc_code = 10'((i * 53) % 1024);
            target   = 10'((i * 97) % 1024);
        end
        check("R7 hold", int'(setting_o), prev);

        // Change of setting in the middle of a period.
        set_to(40);
        repeat (200) @(negedge clk);
        last = 0;
        forever begin
            @(negedge clk);
            if (last == 1 && pwm_o == 1'b0) break;
            last = int'(pwm_o);
        end
        // counter now at 41; strobe here
        b = model(900, 100, prev);
        adc_code  = 10'(900);
        target    = 10'(100);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        prev = b;
        hi = 0;
        if (pwm_o) hi++;
        for (int i = 1; i < 158 - 40; i++) begin
            @(negedge clk);
            if (pwm_o) hi++;
        end
        check("R6 old period undisturbed", hi, 0);
        hi = 0;
        for (int i = 0; i < 160; i++) begin
            @(negedge clk);
            if (pwm_o) hi++;
        end
        check("R6 next period new duty", hi, b + 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule